// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

A synthesizable behavioural model of a single-port synchronous static memory holding 18-bit words. Each word is two byte lanes of nine bits (eight data bits plus one parity bit). Every rising clock edge samples the address, three chip-select inputs, two cycle-start strobes, a burst step input and the write controls. A write stores the sampled data at that same edge under a per-lane mask. A read is not pipelined: once an edge has registered a read address, the stored word flows to the output during the following clock period. An asynchronous active-low output enable and an asynchronous sleep input gate it.

Two start strobes begin a cycle. The processor-side strobe is honoured only while the primary chip select is active, and it always begins a read. The controller-side strobe begins a read or a write, as the write controls decide. When neither strobe is active, the block continues a four-beat burst inside an aligned group of four words, in linear or interleaved order, or it repeats the current word as a wait cycle. The data bus is split into an input bus, an output bus and a drive enable, so the chip-level pad can build the tri-state buffer. A low drive enable stands for high impedance.

Top module: `fts_burst_ram`

## Requirements
- R1: While reset is asserted and after it is released, `dq_en` is 0, and the block stays deselected until an edge starts a selected cycle.
- R2: Lane 0 is word bits [8:0] (data bits [7:0], parity bit 8). Lane 1 is bits [17:9] (data bits [16:9], parity bit 17). With `bw_n` low, `ben_n[k]` low writes lane k and leaves the other lane unchanged.
- R3: `gw_n` low writes all 18 bits, whatever `bw_n` and `ben_n` are.
- R4: With `gw_n` high and `bw_n` high, `ben_n` has no effect: the cycle is a read and memory is unchanged.
- R5: If a cycle starts (a start strobe is honoured) while `ce_pri_n` is high, `ce_hi` is low or `ce_lo_n` is high, the block is deselected and `dq_en` is 0 in the following period.
- R6: `ld_rd_n` low is ignored while `ce_pri_n` is high. The cycle is then decided by `ld_rw_n` and, if that is high, it continues or holds the current burst.
- R7: `ld_rd_n` low with `ce_pri_n` low starts a read at `addr` even when the write controls are active, and writes nothing. An edge that follows with both strobes high and the write controls active writes the current address.
- R8: `ld_rw_n` low with the block selected loads `addr` and reads or writes according to the write controls sampled on the same edge.
- R9: With both strobes high and `step_n` low, the burst moves to its next beat. Address bits above bit 1 stay fixed. Bits [1:0] follow (first+k) mod 4 when `seq_linear` is 1, and first XOR k when it is 0, for beat k = 0..3, wrapping.
- R10: With both strobes high and `step_n` high, the cycle is a wait cycle at the current address (a read or a write, as the write controls decide).
- R11: `dq_en` is 1 exactly when `oe_n` is low, `sleep` is low and the last edge started or continued a selected read. `dq_o` then holds the word stored at the current burst address.
- R12: While `sleep` is high, `dq_en` is 0, and clock edges load no address, advance no burst and write nothing. Memory contents are kept, and the first edge after `sleep` falls works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | AW | External word address |
| ce_pri_n | input | 1 | Primary chip select, active low, also qualifies `ld_rd_n` |
| ce_hi | input | 1 | Chip select, active high |
| ce_lo_n | input | 1 | Chip select, active low |
| ld_rd_n | input | 1 | Processor-side start strobe, active low, always a read |
| ld_rw_n | input | 1 | Controller-side start strobe, active low |
| step_n | input | 1 | Burst step, active low; high holds the address |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write gate, active low |
| ben_n | input | 2 | Per-lane write enables, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous standby, active high |
| dq_i | input | 18 | Write data |
| dq_o | output | 18 | Read data |
| dq_en | output | 1 | Output drive enable (0 means high impedance) |

## Verification
The assertions check on every cycle the things a single edge can show. The drive enable appears only under a low output enable, no sleep and a pending read. No write happens during sleep, under a processor-side start, or with both write gates off. A deselecting start silences the output. A wait cycle or a sleep edge leaves the burst address in place, and a burst step never leaves its aligned group of four. The bench scenarios alone show that data stored through a lane mask or a global write comes back on a later read. They also show the linear and interleaved beat orders with their wrap, that a processor-side start followed by a wait-cycle write lands on the loaded address, and that contents survive sleep and deselects.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  // What the current clock edge does to the burst state.
  typedef enum logic [2:0] {EV_NONE, EV_DESEL, EV_LOAD, EV_ADV, EV_HOLD} ev_t;

  // Low two address bits of beat 'step' of a burst that began at 'first'.
  function automatic logic [1:0] burst_offset(input logic [1:0] first,
                                              input logic [1:0] step,
                                              input logic       linear);
    return linear ? 2'(first + step) : (first ^ step);
  endfunction

  // Lanes written by the write controls, before start-strobe qualification.
  function automatic logic [LANES-1:0] lane_mask(input logic gw_n,
                                                 input logic bw_n,
                                                 input logic [LANES-1:0] ben_n);
    if (!gw_n) return '1;
    if (!bw_n) return ~ben_n;
    return '0;
  endfunction
endpackage

// File: rtl/fts_cycle_ctl.sv
module fts_cycle_ctl
  import fts_pkg::*;
(
  input  logic             ld_rd_n,
  input  logic             ld_rw_n,
  input  logic             step_n,
  input  logic             ce_pri_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] ben_n,
  input  logic             sleep,
  input  logic             active,
  output ev_t              ev,
  output logic [LANES-1:0] wmask
);
  logic selected;
  logic proc_go;
  logic force_rd;

  assign selected = !ce_pri_n && ce_hi && !ce_lo_n;
  assign proc_go  = !ld_rd_n && !ce_pri_n;

  always_comb begin
    ev       = EV_NONE;
    force_rd = 1'b0;
    if (sleep) begin
      ev = EV_NONE;
    end else if (proc_go) begin
      ev       = selected ? EV_LOAD : EV_DESEL;
      force_rd = 1'b1;
    end else if (!ld_rw_n) begin
      ev = selected ? EV_LOAD : EV_DESEL;
    end else if (active) begin
      ev = step_n ? EV_HOLD : EV_ADV;
    end
  end

  always_comb begin
    if ((ev == EV_LOAD || ev == EV_ADV || ev == EV_HOLD) && !force_rd)
      wmask = lane_mask(gw_n, bw_n, ben_n);
    else
      wmask = '0;
  end
endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
  import fts_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ev_t           ev,
  input  logic [AW-1:0] ext_addr,
  input  logic          linear,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] edge_addr,
  output logic          active
);
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;

  assign cur_addr = {base_q[AW-1:2], burst_offset(base_q[1:0], beat_q, linear)};

  // Address used by the write port at this edge.
  always_comb begin
    case (ev)
      EV_LOAD: edge_addr = ext_addr;
      EV_ADV:  edge_addr = {base_q[AW-1:2],
                            burst_offset(base_q[1:0], 2'(beat_q + 2'd1), linear)};
      default: edge_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      active <= 1'b0;
    end else begin
      case (ev)
        EV_LOAD: begin
          base_q <= ext_addr;
          beat_q <= '0;
          active <= 1'b1;
        end
        EV_ADV:   beat_q <= 2'(beat_q + 2'd1);
        EV_DESEL: active <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fts_store.sv
module fts_store
  import fts_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we_lane,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lane[k]) cells[waddr] <= wdata[k*LANE_W +: LANE_W];
    end

    assign rdata[k*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
  import fts_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              ce_pri_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  input  logic              ld_rd_n,
  input  logic              ld_rw_n,
  input  logic              step_n,
  input  logic              gw_n,
  input  logic              bw_n,
  input  logic [LANES-1:0]  ben_n,
  input  logic              seq_linear,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_en
);
  ev_t              ev;
  logic [LANES-1:0] wmask;
  logic             active;
  logic [AW-1:0]    cur_addr;
  logic [AW-1:0]    edge_addr;
  logic             rd_q;

  // Named events for the checker.
  logic wr_ev, adv_ev, load_ev, desel_ev;
  assign wr_ev    = |wmask;
  assign adv_ev   = (ev == EV_ADV);
  assign load_ev  = (ev == EV_LOAD);
  assign desel_ev = (ev == EV_DESEL);

  fts_cycle_ctl u_ctl (
    .ld_rd_n (ld_rd_n),  .ld_rw_n (ld_rw_n), .step_n (step_n),
    .ce_pri_n(ce_pri_n), .ce_hi   (ce_hi),   .ce_lo_n(ce_lo_n),
    .gw_n    (gw_n),     .bw_n    (bw_n),    .ben_n  (ben_n),
    .sleep   (sleep),    .active  (active),
    .ev      (ev),       .wmask   (wmask)
  );

  fts_burst_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .ext_addr (addr),
    .linear   (seq_linear),
    .cur_addr (cur_addr),
    .edge_addr(edge_addr),
    .active   (active)
  );

  fts_store #(.AW(AW)) u_mem (
    .clk    (clk),
    .we_lane(wmask),
    .waddr  (edge_addr),
    .wdata  (dq_i),
    .raddr  (cur_addr),
    .rdata  (dq_o)
  );

  // A selected cycle that writes nothing is a read for the next period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           rd_q <= 1'b0;
    else if (load_ev || adv_ev || ev == EV_HOLD) rd_q <= !wr_ev;
    else if (desel_ev)                    rd_q <= 1'b0;
  end

  assign dq_en = rd_q && !oe_n && !sleep;
endmodule

// File: rtl/fts_burst_ram_chk.sv
module fts_burst_ram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_pri_n,
  input logic          ce_hi,
  input logic          ce_lo_n,
  input logic          ld_rd_n,
  input logic          ld_rw_n,
  input logic          step_n,
  input logic          gw_n,
  input logic          bw_n,
  input logic          seq_linear,
  input logic          oe_n,
  input logic          sleep,
  input logic          dq_en,
  input logic          rd_q,
  input logic          wr_ev,
  input logic          adv_ev,
  input logic [AW-1:0] cur_addr
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!dq_en && !rd_q)
        else $error("R1: output active during reset");
    end
  end

  assert_drive_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en |-> (!oe_n && !sleep && rd_q));

  assert_sleep_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !wr_ev);

  assert_sleep_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(cur_addr) || !$stable(seq_linear)));

  assert_proc_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_rd_n && !ce_pri_n) |-> !wr_ev);

  assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bw_n) |-> !wr_ev);

  assert_desel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && ((!ld_rd_n && !ce_pri_n) || !ld_rw_n) &&
     (ce_pri_n || !ce_hi || ce_lo_n)) |=> !dq_en);

  assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && ld_rd_n && ld_rw_n && step_n) |=>
      ($stable(cur_addr) || !$stable(seq_linear)));

  assert_group_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> $stable(cur_addr[AW-1:2]));
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi),
  .ce_lo_n(ce_lo_n), .ld_rd_n(ld_rd_n), .ld_rw_n(ld_rw_n), .step_n(step_n),
  .gw_n(gw_n), .bw_n(bw_n), .seq_linear(seq_linear), .oe_n(oe_n),
  .sleep(sleep), .dq_en(dq_en), .rd_q(rd_q), .wr_ev(wr_ev),
  .adv_ev(adv_ev), .cur_addr(cur_addr)
);

// File: tb/sim_fts_burst_ram.sv
module sim_fts_burst_ram;
  import fts_pkg::*;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] SEL = 3'b010;  // {ce_pri_n, ce_hi, ce_lo_n}

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ce_pri_n, ce_hi, ce_lo_n, ld_rd_n, ld_rw_n, step_n;
  logic gw_n, bw_n, seq_linear, oe_n, sleep, dq_en;
  logic [1:0]        ben_n;
  logic [AW-1:0]     addr;
  logic [WORD_W-1:0] dq_i, dq_o;

  fts_burst_ram #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .ld_rd_n(ld_rd_n), .ld_rw_n(ld_rw_n), .step_n(step_n),
    .gw_n(gw_n), .bw_n(bw_n), .ben_n(ben_n), .seq_linear(seq_linear),
    .oe_n(oe_n), .sleep(sleep), .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [WORD_W-1:0] mm [DEPTH];
  bit m_act = 0, m_rd = 0;
  logic [AW-1:0] m_base = '0;
  int m_cnt = 0;
  logic [WORD_W-1:0] old_w, new_w;

  task automatic chk(input bit ok, input string tag,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Current burst address as the requirements state it.
  function automatic logic [AW-1:0] model_addr();
    int lo;
    if (seq_linear) lo = (int'(m_base[1:0]) + m_cnt) % 4;
    else            lo = int'(m_base[1:0]) ^ m_cnt;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [1:0] lm);
    if (lm[0]) mm[a][8:0]  = dq_i[8:0];
    if (lm[1]) mm[a][17:9] = dq_i[17:9];
  endtask

  task automatic model_edge();
    bit sel;
    logic [1:0] lm;
    if (sleep) return;
    sel = (ce_pri_n == 1'b0) && ce_hi && (ce_lo_n == 1'b0);
    lm  = !gw_n ? 2'b11 : (!bw_n ? ~ben_n : 2'b00);
    if (!ld_rd_n && !ce_pri_n) begin
      if (sel) begin m_base = addr; m_cnt = 0; m_act = 1; m_rd = 1; end
      else begin m_act = 0; m_rd = 0; end
    end else if (!ld_rw_n) begin
      if (sel) begin
        m_base = addr; m_cnt = 0; m_act = 1;
        model_write(addr, lm);
        m_rd = (lm == 2'b00);
      end else begin m_act = 0; m_rd = 0; end
    end else if (m_act) begin
      if (!step_n) m_cnt = (m_cnt + 1) % 4;
      model_write(model_addr(), lm);
      m_rd = (lm == 2'b00);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic p_n, input logic c_n,
                     input logic s_n, input logic [2:0] ce, input logic g_n,
                     input logic b_n, input logic [1:0] be, input logic [WORD_W-1:0] d,
                     input logic o_n, input logic sl, input string tag);
    bit exp_en;
    addr = a; ld_rd_n = p_n; ld_rw_n = c_n; step_n = s_n;
    {ce_pri_n, ce_hi, ce_lo_n} = ce;
    gw_n = g_n; bw_n = b_n; ben_n = be; dq_i = d; oe_n = o_n; sleep = sl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    exp_en = m_rd && !oe_n && !sleep;
    chk(dq_en == exp_en, {tag, " drive"}, 18'(dq_en), 18'(exp_en));
    if (exp_en) chk(dq_o == mm[model_addr()], {tag, " data"}, dq_o, mm[model_addr()]);
  endtask

  // Plain read start through the controller-side strobe.
  task automatic rd_at(input logic [AW-1:0] a, input string tag);
    cyc(a, 1, 0, 1, SEL, 1, 1, 2'b11, '0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; addr = '0; {ce_pri_n, ce_hi, ce_lo_n} = SEL;
    ld_rd_n = 1; ld_rw_n = 1; step_n = 1; gw_n = 1; bw_n = 1; ben_n = 2'b11;
    seq_linear = 1; oe_n = 0; sleep = 0; dq_i = '0;
    repeat (3) @(negedge clk);
    chk(dq_en == 1'b0, "R1 in reset", 18'(dq_en), 18'd0);
    rst_n = 1;
    @(negedge clk);
    chk(dq_en == 1'b0, "R1 after release", 18'(dq_en), 18'd0);

    // R3 R8: fill every word with a global write started by the controller strobe.
    for (int a = 0; a < DEPTH; a++)
      cyc(AW'(a), 1, 0, 1, SEL, 0, 1, 2'b11, 18'($urandom), 0, 0, "R3 R8 fill");
    for (int a = 0; a < 16; a++) rd_at(AW'(a * 7), "R8 readback");

    // R2: lane 0 only.
    old_w = mm[20]; new_w = 18'h2_5A5A;
    cyc(20, 1, 0, 1, SEL, 1, 0, 2'b10, new_w, 0, 0, "R2 lane0 write");
    rd_at(20, "R2 lane0 read");
    chk(dq_o == {old_w[17:9], new_w[8:0]}, "R2 lane0 only", dq_o, {old_w[17:9], new_w[8:0]});
    old_w = mm[21]; new_w = 18'h1_C3C3;
    cyc(21, 1, 0, 1, SEL, 1, 0, 2'b01, new_w, 0, 0, "R2 lane1 write");
    rd_at(21, "R2 lane1 read");
    chk(dq_o == {new_w[17:9], old_w[8:0]}, "R2 lane1 only", dq_o, {new_w[17:9], old_w[8:0]});

    // R4: lane enables without the gate make a read.
    old_w = mm[22];
    cyc(22, 1, 0, 1, SEL, 1, 1, 2'b00, 18'h0_0F0F, 0, 0, "R4 gate off");
    chk(dq_en && dq_o == old_w, "R4 read unchanged", dq_o, old_w);

    // R5: each chip select inactive on its own.
    cyc(23, 1, 0, 1, 3'b110, 1, 1, 2'b11, '0, 0, 0, "R5 pri");
    chk(dq_en == 1'b0, "R5 pri inactive", 18'(dq_en), 18'd0);
    cyc(23, 1, 0, 1, 3'b000, 1, 1, 2'b11, '0, 0, 0, "R5 hi");
    chk(dq_en == 1'b0, "R5 hi inactive", 18'(dq_en), 18'd0);
    cyc(23, 1, 0, 1, 3'b011, 1, 1, 2'b11, '0, 0, 0, "R5 lo");
    chk(dq_en == 1'b0, "R5 lo inactive", 18'(dq_en), 18'd0);

    // R6: processor strobe ignored while the primary select is inactive.
    rd_at(30, "R6 start");
    cyc(31, 0, 1, 1, 3'b110, 1, 1, 2'b11, '0, 0, 0, "R6 ignored");
    chk(dq_en && dq_o == mm[30], "R6 address kept", dq_o, mm[30]);

    // R7: processor start reads despite write controls; next edge writes.
    old_w = mm[40]; new_w = 18'h3_1234;
    cyc(40, 0, 1, 1, SEL, 0, 1, 2'b11, new_w, 0, 0, "R7 forced read");
    chk(dq_en && dq_o == old_w, "R7 no write on start", dq_o, old_w);
    cyc(55, 1, 1, 1, 3'b110, 0, 1, 2'b11, new_w, 0, 0, "R7 late write");
    chk(dq_en == 1'b0, "R7 no drive on write", 18'(dq_en), 18'd0);
    rd_at(40, "R7 readback");
    chk(dq_o == new_w, "R7 write landed", dq_o, new_w);

    // R9: linear from low bits 01 -> 01,10,11,00.
    seq_linear = 1;
    rd_at(65, "R9 lin start");
    cyc(0, 1, 1, 0, SEL, 1, 1, 2'b11, '0, 0, 0, "R9 lin b1");
    chk(dq_o == mm[66], "R9 linear beat1", dq_o, mm[66]);
    cyc(0, 1, 1, 0, SEL, 1, 1, 2'b11, '0, 0, 0, "R9 lin b2");
    chk(dq_o == mm[67], "R9 linear beat2", dq_o, mm[67]);
    cyc(0, 1, 1, 0, SEL, 1, 1, 2'b11, '0, 0, 0, "R9 lin b3");
    chk(dq_o == mm[64], "R9 linear wrap", dq_o, mm[64]);
    // Interleaved from low bits 10 -> 10,11,00,01.
    @(negedge clk); seq_linear = 0;
    rd_at(66, "R9 ilv start");
    cyc(0, 1, 1, 0, SEL, 1, 1, 2'b11, '0, 0, 0, "R9 ilv b1");
    chk(dq_o == mm[67], "R9 interleaved beat1", dq_o, mm[67]);
    cyc(0, 1, 1, 0, SEL, 1, 1, 2'b11, '0, 0, 0, "R9 ilv b2");
    chk(dq_o == mm[64], "R9 interleaved beat2", dq_o, mm[64]);
    cyc(0, 1, 1, 0, SEL, 1, 1, 2'b11, '0, 0, 0, "R9 ilv b3");
    chk(dq_o == mm[65], "R9 interleaved beat3", dq_o, mm[65]);
    @(negedge clk); seq_linear = 1;

    // R10: wait cycles hold the address.
    rd_at(70, "R10 start");
    cyc(0, 1, 1, 0, SEL, 1, 1, 2'b11, '0, 0, 0, "R10 step");
    cyc(0, 1, 1, 1, SEL, 1, 1, 2'b11, '0, 0, 0, "R10 wait1");
    cyc(0, 1, 1, 1, 3'b101, 1, 1, 2'b11, '0, 0, 0, "R10 wait2");
    chk(dq_o == mm[71], "R10 held address", dq_o, mm[71]);

    // R11: output enable gates the drive.
    cyc(80, 1, 0, 1, SEL, 1, 1, 2'b11, '0, 1, 0, "R11 oe high");
    chk(dq_en == 1'b0, "R11 no drive oe high", 18'(dq_en), 18'd0);
    oe_n = 0; #1;
    chk(dq_en == 1'b1 && dq_o == mm[80], "R11 async enable", dq_o, mm[80]);

    // R12: sleep blocks writes and steps, contents kept.
    old_w = mm[90];
    cyc(90, 1, 0, 1, SEL, 0, 1, 2'b11, 18'h2_AAAA, 0, 1, "R12 sleep write");
    chk(dq_en == 1'b0, "R12 no drive asleep", 18'(dq_en), 18'd0);
    rd_at(90, "R12 wake read");
    chk(dq_o == old_w, "R12 contents kept", dq_o, old_w);
    rd_at(100, "R12 burst start");
    cyc(0, 1, 1, 0, SEL, 1, 1, 2'b11, '0, 0, 1, "R12 sleep step");
    cyc(0, 1, 1, 1, SEL, 1, 1, 2'b11, '0, 0, 0, "R12 after wake");
    chk(dq_o == mm[100], "R12 no advance asleep", dq_o, mm[100]);

    // Constrained random mix.
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ce;
      if (i % 1000 == 999) seq_linear = ~seq_linear;
      ce = ($urandom % 4 != 0) ? SEL : 3'($urandom);
      cyc(AW'($urandom), ($urandom % 4 != 0), ($urandom % 4 != 0),
          1'($urandom), ce, ($urandom % 8 != 0), 1'($urandom), 2'($urandom),
          18'($urandom), ($urandom % 4 == 0), ($urandom % 16 == 0),
          "R2 R3 R7 R8 R9 R10 R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule